// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. Two table base inputs and a 3-bit split value set how the address space is divided. When the split is zero, the lower base serves every address. Otherwise the top `split` bits of the virtual address choose the base: the lower base when they are all zero, the upper base in any other case. The region covered by the lower base halves with each step of the split, from 4GB at zero down to 32MB at seven. Its first-level table therefore needs only 4096 >> split entries and only a correspondingly smaller alignment.

A walk starts when a request is accepted and reads the first-level descriptor. That descriptor either maps a 1MB section at once or points to a 256-entry coarse table. In the second case a second descriptor is read, and it maps a 4KB small page or a 64KB large page. The block reads descriptors through a simple request/response port and keeps at most one walk in flight. It returns the physical address, the two access-permission bits, the 4-bit domain and a fault flag. A second flag tells a first-level fault from a second-level one.

Top module: `xlat_walker`

## Requirements
- R1: With split = 0, every walk reads its first-level descriptor from the table at the lower base (`base0`) at address `{base0[31:14], va[31:20], 2'b00}`.
- R2: With split = N > 0, the lower base is used when `va[31:32-N]` are all zero. Otherwise the upper base (`base1`) is used, at `{base1[31:14], va[31:20], 2'b00}`.
- R3: For the lower base, the descriptor address keeps `base0[31:14-N]`, discards `base0[13-N:0]`, and fills bits [13-N:2] with `va[31-N:20]`. Bits [1:0] are zero.
- R4: First-level type is descriptor bits [1:0]: 2'b10 maps a section, 2'b01 points to a coarse table, and 2'b00 or 2'b11 is a fault.
- R5: A section result gives physical address `{d[31:20], va[19:0]}`, permission `d[11:10]` and domain `d[8:5]`.
- R6: A coarse pointer causes one second-level read at `{d[31:10], va[19:12], 2'b00}`. The domain of the result is the pointer's `d[8:5]`.
- R7: Second-level type 2'b10 is a 4KB small page with physical address `{d2[31:12], va[11:0]}` and permission `d2[5:4]`.
- R8: Second-level type 2'b01 is a 64KB large page with physical address `{d2[31:16], va[15:0]}` and permission `d2[5:4]`.
- R9: Second-level type 2'b00 or 2'b11 gives a fault result with the level flag set to 1, and physical address, permission and domain all zero.
- R10: A first-level fault gives a fault result with the level flag set to 0, and physical address, permission and domain all zero. A non-fault result always has the level flag at 0.
- R11: A request is accepted only while no walk is in flight. A descriptor read request holds its address until it is accepted. A result holds all its fields until `res_ready` is seen, after which the block is ready again. A coarse walk makes exactly two reads.
- R12: After reset the block is ready for a request and drives no read request and no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_vaddr | input | 32 | Virtual address to translate |
| split | input | 3 | Base-split value N |
| base0 | input | 32 | Lower table base |
| base1 | input | 32 | Upper table base |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 32 | Physical address (zero on fault) |
| res_ap | output | 2 | Access-permission bits |
| res_domain | output | 4 | Domain number |
| res_fault | output | 1 | Translation fault |
| res_fault_l2 | output | 1 | Fault arose at second level |

## Verification
The checker covers the handshake rules on every cycle: read requests that stay steady while stalled, results that stay steady while stalled, and the ready signal being exclusive with an in-flight walk. It also checks that faults are zero-filled and that the level flag is only set on a fault. In addition, it ties the first descriptor address to the chosen base when the split is zero or the top address bit selects the upper base. Only the scenarios can show the rest. These are the exact physical addresses, permissions and domains for sections, small pages and large pages, and the masking of the lower base at several split values. The scenarios also cover the read count of a coarse walk, because each of these depends on descriptor contents held in the bench's memory.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int unsigned VA_W     = 32;
    localparam int unsigned SPLIT_W  = 3;
    localparam int unsigned AP_W     = 2;
    localparam int unsigned DOM_W    = 4;
    localparam int unsigned IDX1_W   = 12;               // first-level index width
    localparam int unsigned OFF_W    = VA_W - IDX1_W;    // offset inside a 1MB region
    localparam int unsigned TBL1_B   = 1 << (IDX1_W + 2);// first-level table bytes

    localparam logic [1:0] TY_FAULT = 2'b00;
    localparam logic [1:0] TY_PTR   = 2'b01;             // coarse at L1, large at L2
    localparam logic [1:0] TY_BLK   = 2'b10;             // section at L1, small at L2

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH_L1, ST_WAIT_L1, ST_FETCH_L2, ST_WAIT_L2, ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic             fault;
        logic             leaf;
        logic [VA_W-1:0]  pa;
        logic [AP_W-1:0]  ap;
        logic [DOM_W-1:0] dom;
        logic [VA_W-1:0]  next_addr;
    } desc_info_t;

    typedef struct packed {
        walk_st_e         st;
        logic [VA_W-1:0]  va;
        logic [VA_W-1:0]  addr;
        logic [VA_W-1:0]  pa;
        logic [AP_W-1:0]  ap;
        logic [DOM_W-1:0] dom;
        logic             fault;
        logic             flt_l2;
    } walk_t;
endpackage

// File: rtl/xlat_base_sel.sv
module xlat_base_sel
    import xlat_pkg::*;
(
    input  logic [VA_W-1:0]    va,
    input  logic [SPLIT_W-1:0] split,
    input  logic [VA_W-1:0]    base0,
    input  logic [VA_W-1:0]    base1,
    output logic [VA_W-1:0]    l1_addr
);
    localparam logic [VA_W-1:0] ONES    = {VA_W{1'b1}};
    localparam logic [VA_W-1:0] TBL_MSK = VA_W'(TBL1_B - 1);

    logic [VA_W-1:0] hi_mask;
    logic [VA_W-1:0] lo_keep;
    logic [VA_W-1:0] base_sel;
    logic            use_hi;

    always_comb begin
        hi_mask  = ~(ONES >> split);                     // zero when split is 0
        use_hi   = |(va & hi_mask);
        lo_keep  = ~(TBL_MSK >> split);                  // lower table shrinks with split
        base_sel = use_hi ? (base1 & ~TBL_MSK) : (base0 & lo_keep);
        l1_addr  = base_sel | {{(VA_W-IDX1_W-2){1'b0}}, va[VA_W-1 -: IDX1_W], 2'b00};
    end
endmodule

// File: rtl/xlat_desc_dec.sv
module xlat_desc_dec
    import xlat_pkg::*;
#(
    parameter bit SECOND = 1'b0
)(
    input  logic [OFF_W-1:0]  off,
    input  logic [VA_W-1:0]   desc,
    input  logic [DOM_W-1:0]  dom_in,
    output desc_info_t        info
);
    generate
        if (!SECOND) begin : g_l1
            always_comb begin
                info           = '0;
                info.dom       = desc[8:5];
                info.next_addr = {desc[VA_W-1:10], off[OFF_W-1:12], 2'b00};
                unique case (desc[1:0])
                    TY_BLK: begin
                        info.leaf = 1'b1;
                        info.pa   = {desc[VA_W-1:OFF_W], off};
                        info.ap   = desc[11:10];
                    end
                    TY_PTR:  info.leaf  = 1'b0;
                    default: info.fault = 1'b1;
                endcase
            end
        end else begin : g_l2
            always_comb begin
                info           = '0;
                info.dom       = dom_in;
                info.leaf      = 1'b1;
                info.ap        = desc[5:4];
                unique case (desc[1:0])
                    TY_BLK:  info.pa = {desc[VA_W-1:12], off[11:0]};
                    TY_PTR:  info.pa = {desc[VA_W-1:16], off[15:0]};
                    default: info.fault = 1'b1;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [31:0]        req_vaddr,
    input  logic [2:0]         split,
    input  logic [31:0]        base0,
    input  logic [31:0]        base1,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [31:0]        mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data,
    output logic               res_valid,
    input  logic               res_ready,
    output logic [31:0]        res_paddr,
    output logic [1:0]         res_ap,
    output logic [3:0]         res_domain,
    output logic               res_fault,
    output logic               res_fault_l2
);
    localparam walk_t RST_Q = '{st: ST_IDLE, default: '0};

    walk_t      q, d;
    logic [VA_W-1:0] l1_addr;
    desc_info_t l1_info, l2_info;

    xlat_base_sel u_sel (
        .va(req_vaddr), .split(split), .base0(base0), .base1(base1), .l1_addr(l1_addr)
    );

    xlat_desc_dec #(.SECOND(1'b0)) u_dec_l1 (
        .off(q.va[OFF_W-1:0]), .desc(mem_rsp_data), .dom_in('0), .info(l1_info)
    );

    xlat_desc_dec #(.SECOND(1'b1)) u_dec_l2 (
        .off(q.va[OFF_W-1:0]), .desc(mem_rsp_data), .dom_in(q.dom), .info(l2_info)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: if (req_valid) begin
                d        = RST_Q;
                d.va     = req_vaddr;
                d.addr   = l1_addr;
                d.st     = ST_FETCH_L1;
            end
            ST_FETCH_L1: if (mem_req_ready) d.st = ST_WAIT_L1;
            ST_WAIT_L1: if (mem_rsp_valid) begin
                if (l1_info.fault) begin
                    d.fault = 1'b1;
                    d.st    = ST_DONE;
                end else if (l1_info.leaf) begin
                    d.pa  = l1_info.pa;
                    d.ap  = l1_info.ap;
                    d.dom = l1_info.dom;
                    d.st  = ST_DONE;
                end else begin
                    d.addr = l1_info.next_addr;
                    d.dom  = l1_info.dom;
                    d.st   = ST_FETCH_L2;
                end
            end
            ST_FETCH_L2: if (mem_req_ready) d.st = ST_WAIT_L2;
            ST_WAIT_L2: if (mem_rsp_valid) begin
                d.st = ST_DONE;
                if (l2_info.fault) begin
                    d.fault  = 1'b1;
                    d.flt_l2 = 1'b1;
                    d.dom    = '0;
                end else begin
                    d.pa = l2_info.pa;
                    d.ap = l2_info.ap;
                end
            end
            ST_DONE: if (res_ready) d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_Q;
        else        q <= d;
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st == ST_FETCH_L1) || (q.st == ST_FETCH_L2);
    assign mem_req_addr  = q.addr;
    assign res_valid     = (q.st == ST_DONE);
    assign res_paddr     = q.pa;
    assign res_ap        = q.ap;
    assign res_domain    = q.dom;
    assign res_fault     = q.fault;
    assign res_fault_l2  = q.flt_l2;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic [2:0]  split,
    input logic [31:0] base0,
    input logic [31:0] base1,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        res_valid,
    input logic        res_ready,
    input logic [31:0] res_paddr,
    input logic [1:0]  res_ap,
    input logic [3:0]  res_domain,
    input logic        res_fault,
    input logic        res_fault_l2
);
    AST_SPLIT_ZERO_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && split == 3'd0) |=>
        (mem_req_valid && mem_req_addr[31:14] == $past(base0[31:14]))); // R1

    AST_TOP_BIT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && split != 3'd0 && req_vaddr[31]) |=>
        (mem_req_valid && mem_req_addr[31:14] == $past(base1[31:14]))); // R2

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00); // R3

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr) && $stable(res_ap)
        && $stable(res_domain) && $stable(res_fault) && $stable(res_fault_l2))); // R11

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !res_valid)); // R11

    AST_FAULT_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_paddr == 32'd0 && res_ap == 2'd0 && res_domain == 4'd0)); // R9

    AST_LEVEL_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault) |-> !res_fault_l2); // R10
endmodule

bind xlat_walker xlat_walker_chk u_chk (.*);

// File: tb/tb_xlat_walker.sv
module tb_xlat_walker;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_vaddr = '0;
    logic [2:0]  split = '0;
    logic [31:0] base0 = 32'h0001_0FFF, base1 = 32'h0002_FFFF;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid, res_ready = 1'b0;
    logic [31:0] res_paddr;
    logic [1:0]  res_ap;
    logic [3:0]  res_domain;
    logic        res_fault, res_fault_l2;

    int nchk = 0, nfail = 0, nreads = 0, cyc = 0;
    logic stall_mode = 1'b0;
    logic pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic [31:0] mem [logic [31:0]];

    always #(CLK_NS/2) clk = ~clk;

    xlat_walker dut (.*);

    typedef struct packed {
        logic [2:0]  sp;
        logic [31:0] va;
        logic [31:0] pa;
        logic [1:0]  ap;
        logic [3:0]  dom;
        logic        flt;
        logic        l2;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 32'h8012_3456, 32'hABC2_3456, 2'd3, 4'd5,  1'b0, 1'b0},
        '{3'd1, 32'h8012_3456, 32'h1232_3456, 2'd1, 4'd2,  1'b0, 1'b0},
        '{3'd1, 32'h0010_0ABC, 32'h5555_5ABC, 2'd2, 4'd9,  1'b0, 1'b0},
        '{3'd1, 32'h0010_5DEF, 32'h7777_5DEF, 2'd1, 4'd9,  1'b0, 1'b0},
        '{3'd1, 32'h0010_2000, 32'h0,         2'd0, 4'd0,  1'b1, 1'b1},
        '{3'd1, 32'h0020_0000, 32'h0,         2'd0, 4'd0,  1'b1, 1'b0},
        '{3'd3, 32'h1FE0_0004, 32'h0AB0_0004, 2'd2, 4'd15, 1'b0, 1'b0},
        '{3'd3, 32'h2000_0000, 32'hFFF0_0000, 2'd3, 4'd0,  1'b0, 1'b0},
        '{3'd7, 32'h01F0_0010, 32'h3450_0010, 2'd1, 4'd3,  1'b0, 1'b0},
        '{3'd7, 32'h0200_0000, 32'h0,         2'd0, 4'd0,  1'b1, 1'b0},
        '{3'd0, 32'h0010_3000, 32'h0,         2'd0, 4'd0,  1'b1, 1'b1}
    };

    function automatic string tag_of(int i);
        case (i)
            0: return "R1 R5";
            1: return "R2 R5";
            2: return "R6 R7";
            3: return "R8";
            4: return "R9";
            5: return "R10";
            6: return "R3";
            7: return "R2";
            8: return "R3";
            9: return "R4";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [31:0] rd(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    // descriptor memory: one read in flight, data one cycle after acceptance
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd(pend_addr);
            pend          = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        mem_req_ready = stall_mode ? ((cyc % 3) == 0) : 1'b1;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            pend      = 1'b1;
            pend_addr = mem_req_addr;
            nreads    = nreads + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic walk(input logic [2:0] sp, input logic [31:0] va,
                        output logic [31:0] pa, output logic [7:0] attr);
        @(negedge clk);
        split = sp; req_vaddr = va; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!res_valid) @(negedge clk);
        pa   = res_paddr;
        attr = {res_ap, res_domain, res_fault, res_fault_l2};
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] pa, p0;
        logic [7:0]  attr;
        int r0;
        // first-level descriptors (lower base masked per split, upper at 0x2C000)
        mem[32'h0001_2004] = 32'hABC0_0CA2;   // section ap3 dom5
        mem[32'h0002_E004] = 32'h1230_0442;   // section ap1 dom2
        mem[32'h0001_0004] = 32'h0004_0521;   // coarse at 0x40400 dom9
        mem[32'h0001_0FF8] = 32'h0AB0_09E2;   // section ap2 dom15 (split 3)
        mem[32'h0002_C800] = 32'hFFF0_0C02;   // section ap3 dom0
        mem[32'h0001_0FFC] = 32'h3450_0462;   // section ap1 dom3 (split 7)
        mem[32'h0002_C080] = 32'h0000_0003;   // type 11: fault
        // second-level descriptors
        mem[32'h0004_0400] = 32'h5555_5022;   // small ap2
        mem[32'h0004_0414] = 32'h7777_0011;   // large ap1
        mem[32'h0004_040C] = 32'h0000_0003;   // type 11: fault

        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", {61'd0, req_ready, mem_req_valid, res_valid}, {61'd0, 3'b100});
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            walk(VEC[i].sp, VEC[i].va, pa, attr);
            chk(tag_of(i), {32'd0, pa}, {32'd0, VEC[i].pa});
            chk(tag_of(i), {56'd0, attr}, {56'd0, VEC[i].ap, VEC[i].dom, VEC[i].flt, VEC[i].l2});
        end

        // R11: stalled memory, stalled consumer, coarse walk read count
        stall_mode = 1'b1;
        @(negedge clk);
        split = 3'd1; req_vaddr = 32'h0010_0ABC; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        r0 = nreads;
        @(negedge clk);
        req_valid = 1'b0;
        while (!res_valid) @(negedge clk);
        p0 = res_paddr;
        repeat (3) @(negedge clk);
        chk("R11", {30'd0, res_valid, req_ready, res_paddr}, {30'd0, 2'b10, p0});
        chk("R11", {32'd0, p0}, {32'd0, 32'h5555_5ABC});
        chk("R6 R11", 64'(nreads - r0), 64'd2);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk("R11", {62'd0, req_ready, res_valid}, {62'd0, 2'b10});

        // R5: section walk makes one read, even when memory stalls
        r0 = nreads;
        walk(3'd0, 32'h8012_3456, pa, attr);
        chk("R5 R11", 64'(nreads - r0), 64'd1);
        chk("R5", {32'd0, pa}, {32'd0, 32'hABC2_3456});
        stall_mode = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule